// File: doc/BRIEF.md
# Per-pin interrupt detector for an 8-line I/O port

The block watches a bank of general-purpose input lines and produces interrupt requests from them. Each line has its own settings. One setting chooses whether the line reacts to a steady level or to a transition. A second setting makes any transition count, in either direction. A third sets the active polarity: high or rising when set, low or falling when clear. Every line that meets its condition latches a bit in a raw status register. This happens whether or not the line is enabled.

An enable mask gates raw status into a masked status value. A routing bit sends the masked status to the interrupt outputs in one of two ways. When the bit is clear, all masked lines are ORed onto a single summary request. When it is set, each line drives its own request output. Software clears latched bits by writing ones to a clear location. Pin inputs are first passed through a synchronizer inside the block. Register access uses a simple single-cycle bus with a registered read port.

Top module: `pin_irq_detect`

## Requirements
- R1: After a synchronous reset, every configuration register, the raw status and both interrupt outputs are zero.
- R2: With the sense bit of a line set (offset 0x404), the raw status bit of that line is set on every cycle in which the synchronized line equals its polarity bit (offset 0x40C): 1 means high, 0 means low.
- R3: With sense clear and the both-edges bit clear (offset 0x408), polarity 1 latches the line on a 0-to-1 change and polarity 0 latches it on a 1-to-0 change. A change in the other direction does not latch.
- R4: With sense clear and the both-edges bit set, a change in either direction latches the line, whatever its polarity bit.
- R5: Raw status (read at offset 0x414) latches whatever the enable mask (offset 0x410) holds.
- R6: Masked status (read at offset 0x418) equals raw status AND mask. Only masked bits can drive an interrupt output.
- R7: Writing to offset 0x41C clears each raw bit whose data bit is 1. Bits written as 0 keep their value. A write to offset 0x414 leaves raw status unchanged. Offset 0x41C reads as zero.
- R8: In level mode, a line that is still active sets its raw bit again on the cycle after a clear.
- R9: If a line latches in the same cycle that a clear of that bit is written, the bit stays set.
- R10: The routing bit is bit 0 at offset 0x420. When it is 0, `irq_combined` is the OR of the masked bits and `irq_pin` is zero. When it is 1, `irq_pin` carries the masked bits and `irq_combined` is zero.
- R11: The pins pass through two synchronizer flops. The raw bit is set on the third clock edge after a pin change is first sampled. The interrupt outputs follow raw status one edge later.
- R12: Read data appears one clock edge after the address is presented. It reflects register state before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset of the accessed register |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_wdata | input | 8 | Write data, one bit per line |
| bus_rdata | output | 8 | Registered read data |
| pins_in | input | 8 | Asynchronous line inputs |
| irq_combined | output | 1 | Summary interrupt request |
| irq_pin | output | 8 | Per-line interrupt requests |

## Verification
Assertions check on every cycle that a clear without a simultaneous latch empties the bit, that a latch always survives a clear in the same cycle, that the summary and per-line outputs are never active together, and that no unmasked line reaches an output. Only the bench scenarios show the following: which condition each sense, both-edges and polarity setting selects, the synchronizer latency, re-latching in level mode after a clear, and the mask and read-back values. Each scenario is compared cycle by cycle against a behavioural reference model.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int OFS_W = 12;
  localparam logic [OFS_W-1:0] OFS_SENSE  = 12'h404;
  localparam logic [OFS_W-1:0] OFS_BOTH   = 12'h408;
  localparam logic [OFS_W-1:0] OFS_POL    = 12'h40C;
  localparam logic [OFS_W-1:0] OFS_MASK   = 12'h410;
  localparam logic [OFS_W-1:0] OFS_RAW    = 12'h414;
  localparam logic [OFS_W-1:0] OFS_MASKED = 12'h418;
  localparam logic [OFS_W-1:0] OFS_CLEAR  = 12'h41C;
  localparam logic [OFS_W-1:0] OFS_ROUTE  = 12'h420;

  typedef enum logic {
    ROUTE_SUMMARY = 1'b0,
    ROUTE_PER_PIN = 1'b1
  } irq_route_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int N_PINS = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] pins_i,
  output logic [N_PINS-1:0] cur_o,
  output logic [N_PINS-1:0] prev_o
);
  logic [N_PINS-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg_q[s] <= '0;
          else     stg_q[s] <= pins_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg_q[s] <= '0;
          else     stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_o <= '0;
    else     prev_o <= stg_q[STAGES-1];
  end

  assign cur_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_cond.sv
module irq_cond #(
  parameter int N_PINS = 8
) (
  input  logic [N_PINS-1:0] cur_i,
  input  logic [N_PINS-1:0] prev_i,
  input  logic [N_PINS-1:0] sense_i,
  input  logic [N_PINS-1:0] both_i,
  input  logic [N_PINS-1:0] pol_i,
  output logic [N_PINS-1:0] hit_o
);
  generate
    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
      logic rise, fall, lvl_hit, edge_hit;
      always_comb begin
        rise     = cur_i[p] & ~prev_i[p];
        fall     = ~cur_i[p] & prev_i[p];
        lvl_hit  = (cur_i[p] == pol_i[p]);
        if (both_i[p]) edge_hit = rise | fall;
        else           edge_hit = pol_i[p] ? rise : fall;
        hit_o[p] = sense_i[p] ? lvl_hit : edge_hit;
      end
    end
  endgenerate
endmodule

// File: rtl/irq_status.sv
module irq_status #(
  parameter int N_PINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] hit_i,
  input  logic [N_PINS-1:0] clr_i,
  output logic [N_PINS-1:0] raw_o
);
  always_ff @(posedge clk) begin
    if (rst) raw_o <= '0;
    else     raw_o <= (raw_o & ~clr_i) | hit_i;
  end

  // R7: a clear with no simultaneous hit empties the bit
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    ((clr_i & ~hit_i) != '0) |=> ((raw_o & $past(clr_i & ~hit_i)) == '0));

  // R9: a hit always lands, even against a clear
  p_hit_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (hit_i != '0) |=> ((raw_o & $past(hit_i)) == $past(hit_i)));

  // R7: bits neither hit nor cleared hold their value
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((raw_o & $past(~hit_i & ~clr_i)) == ($past(raw_o) & $past(~hit_i & ~clr_i))));
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pin_irq_pkg::*;
#(
  parameter int N_PINS      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [N_PINS-1:0] bus_wdata,
  output logic [N_PINS-1:0] bus_rdata,
  input  logic [N_PINS-1:0] pins_in,
  output logic              irq_combined,
  output logic [N_PINS-1:0] irq_pin
);
  localparam logic [ADDR_W-1:0] A_SENSE  = ADDR_W'(OFS_SENSE);
  localparam logic [ADDR_W-1:0] A_BOTH   = ADDR_W'(OFS_BOTH);
  localparam logic [ADDR_W-1:0] A_POL    = ADDR_W'(OFS_POL);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFS_MASKED);
  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFS_CLEAR);
  localparam logic [ADDR_W-1:0] A_ROUTE  = ADDR_W'(OFS_ROUTE);

  logic [N_PINS-1:0] sense_q, both_q, pol_q, mask_q;
  irq_route_e        route_q;
  logic [N_PINS-1:0] cur_s, prev_s, hit_s, clr_s, raw_s, masked_s;
  logic [N_PINS-1:0] rd_mux;

  pin_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pins_i(pins_in), .cur_o(cur_s), .prev_o(prev_s)
  );

  irq_cond #(.N_PINS(N_PINS)) u_cond (
    .cur_i(cur_s), .prev_i(prev_s), .sense_i(sense_q), .both_i(both_q),
    .pol_i(pol_q), .hit_o(hit_s)
  );

  irq_status #(.N_PINS(N_PINS)) u_status (
    .clk(clk), .rst(rst), .hit_i(hit_s), .clr_i(clr_s), .raw_o(raw_s)
  );

  assign clr_s    = (bus_wr && bus_addr == A_CLEAR) ? bus_wdata : '0;
  assign masked_s = raw_s & mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      mask_q  <= '0;
      route_q <= ROUTE_SUMMARY;
    end else if (bus_wr) begin
      case (bus_addr)
        A_SENSE: sense_q <= bus_wdata;
        A_BOTH:  both_q  <= bus_wdata;
        A_POL:   pol_q   <= bus_wdata;
        A_MASK:  mask_q  <= bus_wdata;
        A_ROUTE: route_q <= irq_route_e'(bus_wdata[0]);
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      A_SENSE:  rd_mux = sense_q;
      A_BOTH:   rd_mux = both_q;
      A_POL:    rd_mux = pol_q;
      A_MASK:   rd_mux = mask_q;
      A_RAW:    rd_mux = raw_s;
      A_MASKED: rd_mux = masked_s;
      A_ROUTE:  rd_mux = N_PINS'(route_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata    <= '0;
      irq_combined <= 1'b0;
      irq_pin      <= '0;
    end else begin
      bus_rdata <= rd_mux;
      if (route_q == ROUTE_PER_PIN) begin
        irq_pin      <= masked_s;
        irq_combined <= 1'b0;
      end else begin
        irq_pin      <= '0;
        irq_combined <= |masked_s;
      end
    end
  end

  // R1: reset clears outputs and configuration
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!irq_combined && irq_pin == '0 && sense_q == '0 && mask_q == '0));

  // R10: the two routing styles never drive together
  p_route_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(irq_combined && (irq_pin != '0)));

  // R6: an unmasked line never reaches a per-line output
  p_masked_only_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irq_pin & ~$past(mask_q)) == '0));
endmodule

// File: tb/pin_irq_detect_tb.sv
`timescale 1ns/1ps
module pin_irq_detect_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  pins_in = '0;
  logic        irq_combined;
  logic [7:0]  irq_pin;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  pin_irq_detect dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins_in(pins_in),
    .irq_combined(irq_combined), .irq_pin(irq_pin)
  );

  // behavioural reference model, one update per rising edge
  logic [7:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_raw = '0;
  logic [7:0] m_sense = '0, m_both = '0, m_pol = '0, m_mask = '0;
  logic       m_route = 1'b0;
  logic [7:0] m_rdata = '0, m_irq_pin = '0;
  logic       m_irq_comb = 1'b0;

  always @(posedge clk) begin
    logic [7:0] hit, clr, rd, msk;
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_raw = '0;
      m_sense = '0; m_both = '0; m_pol = '0; m_mask = '0; m_route = 1'b0;
      m_rdata = '0; m_irq_pin = '0; m_irq_comb = 1'b0;
    end else begin
      msk = m_raw & m_mask;
      case (bus_addr)
        12'h404: rd = m_sense;
        12'h408: rd = m_both;
        12'h40C: rd = m_pol;
        12'h410: rd = m_mask;
        12'h414: rd = m_raw;
        12'h418: rd = msk;
        12'h420: rd = {7'd0, m_route};
        default: rd = '0;
      endcase
      for (int p = 0; p < 8; p++) begin
        if (m_sense[p]) hit[p] = (m_s2[p] == m_pol[p]);
        else if (m_s2[p] != m_prev[p])
          hit[p] = m_both[p] || (m_pol[p] == m_s2[p]);
        else hit[p] = 1'b0;
      end
      clr = (bus_wr && bus_addr == 12'h41C) ? bus_wdata : 8'h00;
      m_rdata    = rd;
      m_irq_pin  = m_route ? msk : 8'h00;
      m_irq_comb = m_route ? 1'b0 : (msk != 0);
      m_raw      = (m_raw & ~clr) | hit;
      if (bus_wr) begin
        case (bus_addr)
          12'h404: m_sense = bus_wdata;
          12'h408: m_both  = bus_wdata;
          12'h40C: m_pol   = bus_wdata;
          12'h410: m_mask  = bus_wdata;
          12'h420: m_route = bus_wdata[0];
          default: ;
        endcase
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pins_in;
    end
  end

  task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check8(cur_req, "model rdata", bus_rdata, m_rdata);
      check8(cur_req, "model irq_pin", irq_pin, m_irq_pin);
      check8(cur_req, "model irq_combined", {7'd0, irq_combined}, {7'd0, m_irq_comb});
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(string req, logic [11:0] a, logic [7:0] exp);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    check8(req, $sformatf("read %03h", a), bus_rdata, exp);
  endtask

  initial begin
    wait_cyc(4);
    @(negedge clk); rst = 1'b0;

    cur_req = "R1";
    rd_check("R1", 12'h404, 8'h00);
    rd_check("R1", 12'h408, 8'h00);
    rd_check("R1", 12'h40C, 8'h00);
    rd_check("R1", 12'h410, 8'h00);
    rd_check("R1", 12'h414, 8'h00);
    rd_check("R1", 12'h420, 8'h00);
    check8("R1", "irq_combined", {7'd0, irq_combined}, 8'h00);
    check8("R1", "irq_pin", irq_pin, 8'h00);

    cur_req = "R3";
    wr(12'h40C, 8'h05);
    wr(12'h410, 8'hFF);
    @(negedge clk); pins_in[0] = 1'b1;
    wait_cyc(4);
    rd_check("R3", 12'h414, 8'h01);
    @(negedge clk); pins_in[0] = 1'b0; pins_in[1] = 1'b1;
    wait_cyc(4);
    rd_check("R3", 12'h414, 8'h01);

    cur_req = "R10";
    check8("R10", "summary irq_combined", {7'd0, irq_combined}, 8'h01);
    check8("R10", "summary irq_pin", irq_pin, 8'h00);
    wr(12'h420, 8'h01);
    wait_cyc(2);
    check8("R10", "per-pin irq_pin", irq_pin, 8'h01);
    check8("R10", "per-pin irq_combined", {7'd0, irq_combined}, 8'h00);

    cur_req = "R7";
    wr(12'h41C, 8'h00);
    rd_check("R7", 12'h414, 8'h01);
    wr(12'h414, 8'hFF);
    rd_check("R7", 12'h414, 8'h01);
    rd_check("R7", 12'h41C, 8'h00);
    wr(12'h41C, 8'h01);
    rd_check("R7", 12'h414, 8'h00);

    cur_req = "R11";
    @(negedge clk); pins_in[1] = 1'b0;
    wait_cyc(4);
    rd_check("R3", 12'h414, 8'h02);
    wr(12'h41C, 8'hFF);

    cur_req = "R5";
    wr(12'h420, 8'h00);
    wr(12'h410, 8'h00);
    @(negedge clk); pins_in[2] = 1'b1;
    wait_cyc(4);
    rd_check("R5", 12'h414, 8'h04);
    cur_req = "R6";
    rd_check("R6", 12'h418, 8'h00);
    check8("R6", "masked-off irq_combined", {7'd0, irq_combined}, 8'h00);
    wr(12'h410, 8'h06);
    rd_check("R6", 12'h418, 8'h04);
    check8("R6", "enabled irq_combined", {7'd0, irq_combined}, 8'h01);
    wr(12'h41C, 8'hFF);

    cur_req = "R4";
    wr(12'h408, 8'h08);
    @(negedge clk); pins_in[3] = 1'b1;
    wait_cyc(4);
    rd_check("R4", 12'h414, 8'h08);
    wr(12'h41C, 8'hFF);
    @(negedge clk); pins_in[3] = 1'b0;
    wait_cyc(4);
    rd_check("R4", 12'h414, 8'h08);
    wr(12'h41C, 8'hFF);

    cur_req = "R2";
    wr(12'h40C, 8'h15);
    wr(12'h404, 8'h10);
    rd_check("R2", 12'h414, 8'h00);
    @(negedge clk); pins_in[4] = 1'b1;
    wait_cyc(4);
    rd_check("R2", 12'h414, 8'h10);
    cur_req = "R8";
    wr(12'h41C, 8'h10);
    rd_check("R8", 12'h414, 8'h10);
    @(negedge clk); pins_in[4] = 1'b0;
    wait_cyc(4);
    wr(12'h41C, 8'h10);
    rd_check("R2", 12'h414, 8'h00);

    cur_req = "R9";
    wr(12'h408, 8'h48);
    @(negedge clk); pins_in[6] = 1'b1;
    wait_cyc(4);
    rd_check("R9", 12'h414, 8'h40);
    @(negedge clk); pins_in[6] = 1'b0;
    @(negedge clk);
    @(negedge clk); bus_addr = 12'h41C; bus_wr = 1'b1; bus_wdata = 8'h40;
    @(negedge clk); bus_wr = 1'b0;
    rd_check("R9", 12'h414, 8'h40);
    wr(12'h41C, 8'h40);
    rd_check("R7", 12'h414, 8'h00);

    cur_req = "R2";
    wr(12'h404, 8'h30);
    wait_cyc(2);
    rd_check("R2", 12'h414, 8'h20);

    cur_req = "R12";
    rd_check("R12", 12'h404, 8'h30);
    wait_cyc(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule